// File: doc/BRIEF.md
# Fetch and Indirect Cycle Sequencer

This block is the front end of a small accumulator-style processor. It owns the program counter, the memory address register, the memory buffer register and the instruction register. It steps through the register transfers that bring the next instruction word in from memory, one transfer group per clock. Each clock is one time unit.

When the fetched word asks for indirect addressing, the block runs three more time units. It reads the pointer word at the instruction's address and writes the pointer's low bits into the instruction register's address field. It also clears the indirect flag. An execute stage therefore only ever receives a direct address. The block then offers the decoded opcode and address with `exec_valid_o`. It waits for a one-cycle completion pulse before it starts the next fetch.

Memory is read through a single-port interface. The memory is expected to return the word at `mem_addr_o` on `mem_rdata_i` during the same clock, and the block captures it at the closing edge of that clock. No register is written and read from memory in the same time unit. The buffer register is never loaded from memory in the unit in which it is copied into the instruction register.

Top module: `fetch_ind_seq`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), PC, MAR, MBR and IR are zero, `exec_valid_o` and `mem_re_o` are low, and the block sits in the first fetch unit. After release, fetching starts again from address 0.
- R2: In the first fetch unit, MAR takes the value of PC and no memory read is issued. `mem_addr_o` always shows MAR.
- R3: In the second fetch unit, `mem_re_o` is high with `mem_addr_o` equal to the PC value at the start of the instruction. MBR captures `mem_rdata_i`, and PC advances by one (modulo 2^12) at the same edge. PC changes in no other unit.
- R4: In the third fetch unit, IR takes the MBR value and no memory read is issued.
- R5: Instruction word layout: bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. When bit 15 is 0, `exec_valid_o` goes high after exactly 3 clock edges, counted from the start of the first fetch unit.
- R6: When bit 15 is 1, an indirect cycle runs after fetch. First MAR takes IR[11:0]. Next, one read at that address loads MBR. Last, IR[11:0] takes MBR[11:0] and IR[15] is cleared, while the opcode is kept and the pointer's bits 15:12 are ignored. `exec_valid_o` goes high after exactly 6 edges.
- R7: `exec_valid_o` stays high, with `exec_opcode_o` and `exec_addr_o` stable, until `exec_done_i` is sampled high. `exec_valid_o` is low one cycle later, and the next fetch starts at that point.
- R8: `exec_done_i` has no effect outside the execute wait, so the fetch and indirect timing is unchanged while it is held high.
- R9: Whenever `exec_valid_o` is high, IR[15] (`ir_o[15]`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one time unit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 12 | Memory read address (MAR) |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 16 | Word at `mem_addr_o`, valid in the same cycle |
| exec_valid_o | output | 1 | Direct-address instruction ready for execute |
| exec_opcode_o | output | 3 | Opcode field of IR |
| exec_addr_o | output | 12 | Direct address field of IR |
| exec_done_i | input | 1 | Execute stage finished (sampled only while waiting) |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |

## Verification
A direct instruction is offered 3 edges after its first fetch unit begins, and an indirect one 6 edges after. PC has already advanced at the second of those edges, and the completion pulse drops `exec_valid_o` at the next edge. The bench drives and samples only on falling edges and counts falling edges from the start of each instruction. Each count must match 3 or 6 exactly. A monitor that records reads at rising edges checks the number of memory reads and the address of each one. An asynchronous reset in the middle of an instruction is checked 1 ns after it is asserted, with no clock edge in between.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [2:0] {
    ST_F1, ST_F2, ST_F3, ST_I1, ST_I2, ST_I3, ST_EXEC
  } seq_st_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic pc_inc;
    logic ir_from_mbr;
    logic ir_addr_wb;
  } uop_t;
endpackage

// File: rtl/fis_ctrl.sv
module fis_ctrl
  import fis_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    mbr_ind_i,
  input  logic    exec_done_i,
  output seq_st_e state_o,
  output uop_t    uop_o,
  output logic    exec_valid_o
);
  seq_st_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F1;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_F1:   state_d = ST_F2;
      ST_F2:   state_d = ST_F3;
      // IR is still being loaded here, so the route is taken from MBR
      ST_F3:   state_d = mbr_ind_i ? ST_I1 : ST_EXEC;
      ST_I1:   state_d = ST_I2;
      ST_I2:   state_d = ST_I3;
      ST_I3:   state_d = ST_EXEC;
      ST_EXEC: state_d = exec_done_i ? ST_F1 : ST_EXEC;
      default: state_d = ST_F1;
    endcase
  end

  always_comb begin
    uop_o = '0;
    unique case (state_q)
      ST_F1: uop_o.mar_from_pc = 1'b1;
      ST_F2: begin
        uop_o.mbr_from_mem = 1'b1;
        uop_o.pc_inc       = 1'b1;
      end
      ST_F3: uop_o.ir_from_mbr  = 1'b1;
      ST_I1: uop_o.mar_from_ir  = 1'b1;
      ST_I2: uop_o.mbr_from_mem = 1'b1;
      ST_I3: uop_o.ir_addr_wb   = 1'b1;
      default: ;
    endcase
  end

  assign state_o      = state_q;
  assign exec_valid_o = (state_q == ST_EXEC);

  AST_FETCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_F1 |=> state_q == ST_F2); // R2
  AST_IND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_I1 |=> state_q == ST_I2); // R6
endmodule

// File: rtl/fis_regs.sv
module fis_regs
  import fis_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 3,
  localparam int DATA_W = 1 + OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  uop_t              uop_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] ir_o
);
  localparam int IND_BIT = DATA_W - 1;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (uop_i.mar_from_pc)  mar_q <= pc_q;
      if (uop_i.mar_from_ir)  mar_q <= ir_q[ADDR_W-1:0];
      if (uop_i.mbr_from_mem) mbr_q <= mem_rdata_i;
      if (uop_i.pc_inc)       pc_q  <= pc_q + ADDR_W'(1);
      if (uop_i.ir_from_mbr)  ir_q  <= mbr_q;
      if (uop_i.ir_addr_wb) begin
        ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
        ir_q[IND_BIT]    <= 1'b0;
      end
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;
endmodule

// File: rtl/fetch_ind_seq.sv
module fetch_ind_seq
  import fis_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 3,
  localparam int DATA_W = 1 + OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              exec_valid_o,
  output logic [OPC_W-1:0]  exec_opcode_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  input  logic              exec_done_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o
);
  localparam int IND_BIT = DATA_W - 1;

  seq_st_e           state;
  uop_t              uop;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir;

  fis_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mbr_ind_i    (mbr[IND_BIT]),
    .exec_done_i  (exec_done_i),
    .state_o      (state),
    .uop_o        (uop),
    .exec_valid_o (exec_valid_o)
  );

  fis_regs #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uop_i       (uop),
    .mem_rdata_i (mem_rdata_i),
    .pc_o        (pc),
    .mar_o       (mar),
    .mbr_o       (mbr),
    .ir_o        (ir)
  );

  assign mem_addr_o    = mar;
  assign mem_re_o      = uop.mbr_from_mem;
  assign exec_opcode_o = ir[IND_BIT-1:ADDR_W];
  assign exec_addr_o   = ir[ADDR_W-1:0];
  assign pc_o          = pc;
  assign ir_o          = ir;

  AST_MAR_FROM_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_F1 |=> mar == $past(pc)); // R2
  AST_NO_EARLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_F1 |-> !mem_re_o); // R2
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_F2 |=> pc == ADDR_W'($past(pc) + 1'b1)); // R3
  AST_PC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != ST_F2 |=> $stable(pc)); // R3
  AST_IR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_F3 |=> ir == $past(mbr)); // R4
  AST_MBR_NO_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_F3 |-> !mem_re_o); // R4
  AST_IND_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_F3 && mbr[IND_BIT]) |=> state == ST_I1); // R6
  AST_IND_WRITEBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_I3 |=> (ir[ADDR_W-1:0] == $past(mbr[ADDR_W-1:0])) && !ir[IND_BIT]
                       && (ir[IND_BIT-1:ADDR_W] == $past(ir[IND_BIT-1:ADDR_W]))); // R6
  AST_EXEC_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> !ir[IND_BIT]); // R9
  AST_EXEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && !exec_done_i) |=> exec_valid_o && $stable(exec_addr_o)
                                       && $stable(exec_opcode_o)); // R7
  AST_EXEC_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && exec_done_i) |=> !exec_valid_o); // R7
endmodule

// File: tb/sim_fetch_ind_seq.sv
module sim_fetch_ind_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic        mem_re;
  logic [15:0] mem_rdata;
  logic        exec_valid;
  logic [2:0]  exec_op;
  logic [11:0] exec_addr;
  logic        exec_done;
  logic [11:0] pc;
  logic [15:0] ir;

  always #10 clk = ~clk; // 50 MHz

  fetch_ind_seq u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mem_addr_o    (mem_addr),
    .mem_re_o      (mem_re),
    .mem_rdata_i   (mem_rdata),
    .exec_valid_o  (exec_valid),
    .exec_opcode_o (exec_op),
    .exec_addr_o   (exec_addr),
    .exec_done_i   (exec_done),
    .pc_o          (pc),
    .ir_o          (ir)
  );

  logic [15:0] mem [64];
  assign mem_rdata = mem[mem_addr[5:0]];

  // read monitor: samples pre-edge values at each rising edge
  int          rd_total = 0;
  logic [11:0] rd_log [64];
  always @(posedge clk) begin
    if (rst_n && mem_re) begin
      rd_log[rd_total % 64] <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!exec_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  localparam logic [15:0] V_INSTR [6] = '{16'h1005, 16'hA020, 16'h7FFF, 16'h8021, 16'hC022, 16'h3000};
  localparam logic [2:0]  V_OP    [6] = '{3'd1, 3'd2, 3'd7, 3'd0, 3'd4, 3'd3};
  localparam logic [11:0] V_ADDR  [6] = '{12'h005, 12'h0AB, 12'hFFF, 12'hFFF, 12'h000, 12'h000};
  localparam int          V_LAT   [6] = '{3, 6, 3, 6, 6, 3};

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    int r0;
    bit hold_ok;
    for (int a = 0; a < 64; a++) mem[a] = 16'h0000;
    for (int a = 0; a < 6; a++) mem[a] = V_INSTR[a];
    mem[32] = 16'hF0AB;
    mem[33] = 16'h8FFF;
    mem[34] = 16'h0000;
    mem[6]  = 16'h9023;
    mem[35] = 16'h0ABC;
    mem[7]  = 16'h2010;
    rst_n = 1'b0;
    exec_done = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 ir", 32'(ir), 0);
    chk("R1 mar", 32'(mem_addr), 0);
    chk("R1 valid", 32'(exec_valid), 0);
    chk("R1 re", 32'(mem_re), 0);
    exec_done = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      r0 = rd_total;
      wait_valid(n);
      chk(V_LAT[i] == 3 ? "R5 latency" : "R6 latency", 32'(n), 32'(V_LAT[i]));
      chk("R5 opcode", 32'(exec_op), 32'(V_OP[i]));
      chk("R6 addr", 32'(exec_addr), 32'(V_ADDR[i]));
      chk("R9 direct flag", 32'(ir[15]), 0);
      chk("R3 read count", 32'(rd_total - r0), V_LAT[i] == 3 ? 1 : 2);
      chk("R3 fetch addr", 32'(rd_log[r0 % 64]), 32'(i));
      if (V_LAT[i] == 6)
        chk("R6 pointer addr", 32'(rd_log[(r0 + 1) % 64]), 32'(V_INSTR[i][11:0]));
      chk("R3 pc", 32'(pc), 32'(i + 1));
      hold_ok = 1'b1;
      repeat (i) begin
        @(negedge clk);
        if (!exec_valid || exec_addr !== V_ADDR[i] || exec_op !== V_OP[i]) hold_ok = 1'b0;
      end
      chk("R7 hold", 32'(hold_ok), 1);
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
      chk("R7 release", 32'(exec_valid), 0);
    end

    // done held high through fetch and indirect cycle
    exec_done = 1'b1;
    wait_valid(n);
    chk("R8 latency", 32'(n), 6);
    chk("R6 pointer high bits ignored", 32'(exec_addr), 32'h0ABC);
    chk("R6 opcode kept", 32'(exec_op), 1);
    @(negedge clk);
    chk("R8 release", 32'(exec_valid), 0);
    exec_done = 1'b0;

    // asynchronous reset mid fetch
    @(negedge clk);
    @(negedge clk);
    chk("R3 pc mid fetch", 32'(pc), 8);
    #3 rst_n = 1'b0;
    #1;
    chk("R1 async pc", 32'(pc), 0);
    chk("R1 async ir", 32'(ir), 0);
    chk("R1 async re", 32'(mem_re), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_valid(n);
    chk("R1 restart latency", 32'(n), 3);
    chk("R1 restart addr", 32'(exec_addr), 12'h005);
    chk("R1 restart opcode", 32'(exec_op), 1);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule